// File: doc/BRIEF.md
# Byte-Code Stream Expander

This block turns a compressed byte stream back into its original bytes. Each compressed code is one opcode byte. Depending on its top bits, the opcode asks for a run of zero bytes, a run of all-ones bytes, a block of literal bytes copied from the input, or an entry from a fixed 128-entry dictionary. Low dictionary entries give one byte and high entries give a byte pair. One code value ends the stream. The block then raises a done flag and stays idle until reset.

Compressed bytes enter on a valid/ready input. Expanded bytes leave on a valid/ready output, one byte per accepted beat. Back-pressure from the output stalls decoding without losing or repeating bytes. The dictionary comes from a parameter. Its default contents are computed rather than tabulated.

Top module: `byte_unpacker`

## Requirements
- R1: After reset, inReady is 1 and outValid, done and err are 0.
- R2: The opcode 0x00 ends the stream. done then goes to 1 and stays at 1 until reset, and inReady and outValid both stay at 0.
- R3: An opcode with top bits 001 emits N bytes of 0x00, where N is the opcode's low five bits (1 to 31).
- R4: An opcode with top bits 010 emits N bytes of 0xFF, where N is the opcode's low five bits.
- R5: An opcode with top bits 011 copies the next N input bytes unchanged to the output. This holds even when those bytes have opcode values.
- R6: An opcode with bit 7 set and low seven bits i in 1..95 emits one byte from dictionary entry i. With the default dictionary, that byte is (i*29+7) mod 256.
- R7: An opcode with bit 7 set and low seven bits i in 96..127 emits two bytes: first the entry's first byte, then its second. With the default dictionary these are (i*5) mod 256 and then 255-i. The next opcode is not taken until both bytes have been accepted.
- R8: A run or literal opcode with N=0 produces no output. So does any opcode 0x01..0x1F. Decoding continues with the next byte.
- R9: The opcode 0x80 produces no output and sets err. err stays at 1 until reset, and decoding continues.
- R10: While outValid is 1 and outReady is 0, outValid stays at 1 and outData holds its value. Each expected byte appears exactly once, in order, under any pattern of outReady.
- R11: During a literal block, inReady equals outReady and outData equals inData, so literal bytes pass through with no buffering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Compressed byte available |
| inData | input | 8 | Compressed byte |
| inReady | output | 1 | Block accepts the compressed byte |
| outValid | output | 1 | Expanded byte available |
| outData | output | 8 | Expanded byte |
| outReady | input | 1 | Sink accepts the expanded byte |
| done | output | 1 | End-of-stream code seen |
| err | output | 1 | Sticky flag for the reserved 0x80 code |

## Verification
The output-stability property assumes that the upstream source holds inValid and inData steady until the byte is taken. This matters because literal bytes reach outData combinationally. The bench driver keeps to this rule: once it offers a byte, it withdraws it only after a handshake. Both handshake sides are otherwise stalled at random, and opcodes, lengths and literal values are randomised. Each stream ends with the 0x00 code, so the model always knows when done must appear.

// File: rtl/unpk_pkg.sv
`timescale 1ns/1ps
package unpk_pkg;
  localparam int ByteW     = 8;
  localparam int DictDepth = 128;
  localparam int EntryW    = 2 * ByteW;

  typedef struct packed {
    logic loadCnt;
    logic loadFill;
    logic decCnt;
    logic loadIdx;
    logic selFill;
    logic selLit;
    logic selDict;
    logic selSecond;
  } ctrlStrobes_t;

  // entry layout: [15:8] first byte, [7:0] second byte (pairs only)
  function automatic logic [EntryW-1:0] defaultEntry(int i, int singles);
    logic [ByteW-1:0] a, b;
    if (i < singles) begin
      a = ByteW'((i * 29 + 7) % 256);
      b = '0;
    end else begin
      a = ByteW'((i * 5) % 256);
      b = ByteW'(255 - i);
    end
    return {a, b};
  endfunction

  function automatic logic [DictDepth*EntryW-1:0] defaultDict(int singles);
    logic [DictDepth*EntryW-1:0] d;
    d = '0;
    for (int i = 0; i < DictDepth; i++) d[i*EntryW +: EntryW] = defaultEntry(i, singles);
    return d;
  endfunction
endpackage

// File: rtl/unpk_ctrl.sv
`timescale 1ns/1ps
module unpk_ctrl
  import unpk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [ByteW-1:0] inData,
  input  logic             outReady,
  input  logic             cntIsOne,
  input  logic             isPair,
  output logic             inReady,
  output logic             outValid,
  output logic             done,
  output logic             err,
  output ctrlStrobes_t     strobes
);
  typedef enum logic [2:0] {S_FETCH, S_RUN, S_LIT, S_DICT1, S_DICT2, S_DONE} state_t;
  state_t state, nextState;
  logic errSet;
  logic [4:0] lenField;

  assign lenField = inData[4:0];

  always_comb begin
    nextState = state;
    strobes   = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    errSet    = 1'b0;
    case (state)
      S_FETCH: begin
        inReady = 1'b1;
        if (inValid) begin
          if (inData[7]) begin
            if (inData[6:0] == '0) errSet = 1'b1;
            else begin
              strobes.loadIdx = 1'b1;
              nextState = S_DICT1;
            end
          end else begin
            case (inData[6:5])
              2'b00: if (inData == '0) nextState = S_DONE;
              2'b01, 2'b10: if (lenField != '0) begin
                strobes.loadCnt  = 1'b1;
                strobes.loadFill = 1'b1;
                nextState = S_RUN;
              end
              default: if (lenField != '0) begin
                strobes.loadCnt = 1'b1;
                nextState = S_LIT;
              end
            endcase
          end
        end
      end
      S_RUN: begin
        outValid        = 1'b1;
        strobes.selFill = 1'b1;
        if (outReady) begin
          strobes.decCnt = 1'b1;
          if (cntIsOne) nextState = S_FETCH;
        end
      end
      S_LIT: begin
        strobes.selLit = 1'b1;
        outValid = inValid;
        inReady  = outReady;
        if (inValid && outReady) begin
          strobes.decCnt = 1'b1;
          if (cntIsOne) nextState = S_FETCH;
        end
      end
      S_DICT1: begin
        outValid        = 1'b1;
        strobes.selDict = 1'b1;
        if (outReady) nextState = isPair ? S_DICT2 : S_FETCH;
      end
      S_DICT2: begin
        outValid          = 1'b1;
        strobes.selDict   = 1'b1;
        strobes.selSecond = 1'b1;
        if (outReady) nextState = S_FETCH;
      end
      default: nextState = S_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_FETCH;
      err   <= 1'b0;
    end else begin
      state <= nextState;
      if (errSet) err <= 1'b1;
    end
  end

  assign done = (state == S_DONE);
endmodule

// File: rtl/unpk_data.sv
`timescale 1ns/1ps
module unpk_data
  import unpk_pkg::*;
#(
  parameter int SINGLES = 96,
  parameter logic [DictDepth*EntryW-1:0] DICT_INIT = defaultDict(96)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ByteW-1:0] inData,
  input  ctrlStrobes_t     strobes,
  output logic             cntIsOne,
  output logic             isPair,
  output logic [ByteW-1:0] outData
);
  localparam int CntW = 5;
  localparam int IdxW = $clog2(DictDepth);

  logic [CntW-1:0]   cnt;
  logic              fillOnes;
  logic [IdxW-1:0]   idx;
  logic [EntryW-1:0] entry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      fillOnes <= 1'b0;
      idx      <= '0;
    end else begin
      if (strobes.loadCnt)     cnt <= inData[CntW-1:0];
      else if (strobes.decCnt) cnt <= cnt - 1'b1;
      if (strobes.loadFill) fillOnes <= inData[6];
      if (strobes.loadIdx)  idx <= inData[IdxW-1:0];
    end
  end

  assign entry    = DICT_INIT[int'(idx)*EntryW +: EntryW];
  assign isPair   = (int'(idx) >= SINGLES);
  assign cntIsOne = (cnt == CntW'(1));

  always_comb begin
    outData = '0;
    if (strobes.selFill)      outData = {ByteW{fillOnes}};
    else if (strobes.selLit)  outData = inData;
    else if (strobes.selDict) outData = strobes.selSecond ? entry[ByteW-1:0] : entry[EntryW-1:ByteW];
  end
endmodule

// File: rtl/byte_unpacker.sv
`timescale 1ns/1ps
module byte_unpacker
  import unpk_pkg::*;
#(
  parameter int SINGLES = 96,
  parameter logic [DictDepth*EntryW-1:0] DICT_INIT = defaultDict(96)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  output logic       outValid,
  output logic [7:0] outData,
  input  logic       outReady,
  output logic       done,
  output logic       err
);
  ctrlStrobes_t strobes;
  logic cntIsOne, isPair;

  unpk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .outReady(outReady),
    .cntIsOne(cntIsOne), .isPair(isPair), .inReady(inReady), .outValid(outValid),
    .done(done), .err(err), .strobes(strobes)
  );

  unpk_data #(.SINGLES(SINGLES), .DICT_INIT(DICT_INIT)) u_data (
    .clk(clk), .rstN(rstN), .inData(inData), .strobes(strobes),
    .cntIsOne(cntIsOne), .isPair(isPair), .outData(outData)
  );
endmodule

// File: rtl/unpk_checker.sv
`timescale 1ns/1ps
module unpk_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] inData,
  input logic       inReady,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outReady,
  input logic       done,
  input logic       err
);
  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> done);
  // R2
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> (!inReady && !outValid));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) err |=> err);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
  // R11
  lit_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && inReady) |-> (outData == inData && outReady));
endmodule

bind byte_unpacker unpk_checker u_unpkChk (.*);

// File: tb/byte_unpacker_bench.sv
`timescale 1ns/1ps
module byte_unpacker_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, inValid = 1'b0, outReady = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, outValid, done, err;
  logic [7:0] outData;

  byte_unpacker u_byte_unpacker (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady), .done(done), .err(err)
  );

  int compared = 0, mismatched = 0, totalCycles = 0;
  logic [7:0] srcQ[$];
  logic [7:0] expQ[$];
  string tagQ[$];
  bit expErr;

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void buildModel();
    int p = 0;
    expQ.delete(); tagQ.delete(); expErr = 0;
    while (p < srcQ.size()) begin
      int op = srcQ[p]; int n = op & 31;
      p++;
      if (op == 0) break;
      if (op >= 128) begin
        int i = op - 128;
        if (i == 0) expErr = 1;
        else if (i < 96) begin expQ.push_back(8'((i*29+7)%256)); tagQ.push_back("R6"); end
        else begin
          expQ.push_back(8'((i*5)%256)); tagQ.push_back("R7");
          expQ.push_back(8'(255-i));     tagQ.push_back("R7");
        end
      end else if (op >= 96) begin
        for (int k = 0; k < n; k++) begin expQ.push_back(srcQ[p]); tagQ.push_back("R5"); p++; end
      end else if (op >= 64) begin
        for (int k = 0; k < n; k++) begin expQ.push_back(8'hFF); tagQ.push_back("R4"); end
      end else if (op >= 32) begin
        for (int k = 0; k < n; k++) begin expQ.push_back(8'h00); tagQ.push_back("R3"); end
      end
    end
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic runStream(string endTag, int readyPct, int validPct);
    bit taken = 0;
    int cyc = 0;
    buildModel();
    @(negedge clk); rstN = 0; inValid = 0; outReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #8;
    // R1
    check(inReady && !outValid && !done && !err, "R1",
          {inReady, outValid, done, err}, 4'b1000);
    while (!done) begin
      @(negedge clk);
      totalCycles++; cyc++;
      if (totalCycles > 150000) begin
        mismatched++; $display("FAIL watchdog R2 actual=0 expected=1"); finishRun();
      end
      if (cyc > 5000) begin
        check(0, {endTag, " R2 timeout"}, done, 1);
        break;
      end
      if (taken) begin inValid = 0; taken = 0; end
      if (!inValid && srcQ.size() > 0 && $urandom_range(99) < validPct) begin
        inValid = 1; inData = srcQ[0];
      end
      outReady = ($urandom_range(99) < readyPct);
      #8;
      if (outValid && tagQ.size() > 0 && tagQ[0] == "R5")
        check(inReady == outReady, "R11", inReady, outReady);
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(0, "R10 extra byte", outData, 0);
        else begin
          check(outData == expQ[0], {tagQ[0], " R10"}, outData, expQ[0]);
          void'(expQ.pop_front()); void'(tagQ.pop_front());
        end
      end
      if (inValid && inReady) begin void'(srcQ.pop_front()); taken = 1; end
    end
    @(negedge clk); inValid = 0;
    check(expQ.size() == 0, {endTag, " R10 missing bytes"}, expQ.size(), 0);
    check(err == expErr, "R9", err, expErr);
    // R2: further input is ignored after the end code
    inValid = 1; inData = 8'h25; outReady = 1;
    repeat (4) begin
      @(negedge clk); #8;
      check(done && !inReady && !outValid, "R2", {done, inReady, outValid}, 3'b100);
    end
    inValid = 0;
    srcQ.delete();
  endtask

  initial begin
    // R3 R4 R5 R6 R7 with full throughput
    srcQ = '{8'h23, 8'h42, 8'h63, 8'h00, 8'h85, 8'h3A, 8'h85, 8'hE4, 8'h00};
    runStream("R3", 100, 100);
    // R8 no-ops and R9 error code
    srcQ = '{8'h20, 8'h40, 8'h60, 8'h80, 8'h21, 8'h05, 8'h1F, 8'h41, 8'h00};
    runStream("R8", 100, 100);
    // maximum lengths, dictionary bounds, heavy back-pressure (R10)
    srcQ = '{8'h3F, 8'h5F, 8'h7F};
    for (int i = 0; i < 31; i++) srcQ.push_back(8'(i * 7 + 3));
    srcQ.push_back(8'hFF); srcQ.push_back(8'hDF); srcQ.push_back(8'hE0);
    srcQ.push_back(8'h81); srcQ.push_back(8'hBF); srcQ.push_back(8'h00);
    runStream("R7", 40, 60);
    // random mix
    for (int rep = 0; rep < 3; rep++) begin
      srcQ.delete();
      for (int k = 0; k < 40; k++) begin
        int kind = $urandom_range(3);
        int n = $urandom_range(31);
        if (kind == 0) srcQ.push_back(8'(32 + n));
        else if (kind == 1) srcQ.push_back(8'(64 + n));
        else if (kind == 2) begin
          srcQ.push_back(8'(96 + n));
          for (int j = 0; j < n; j++) srcQ.push_back(8'($urandom_range(255)));
        end else srcQ.push_back(8'(128 + $urandom_range(1, 127)));
      end
      srcQ.push_back(8'h00);
      runStream("R10", 50 + rep * 20, 70 + rep * 10);
    end
    finishRun();
  end
endmodule